// File: doc/BRIEF.md
# Secondary Core Reset and Power Controller

This block lets a primary processor (A) govern the reset, boot selection and clock of a secondary processor (B), and reports B's reset activity and power state back to A. A writes a small core-control word that can force B into reset, hold it there, mask B's own request to reset A, keep B's clock alive through B's stop mode, and pick the boot source B fetches from when it leaves reset.

On the return path, the block turns four kinds of B-side activity into sticky status bits: B leaving reset, B entering reset, B starting a unit reset, and B requesting a hardware reset of A. Each bit is set on the rising edge of its indication and cleared when A writes 1 to it. A separate enable word selects which of these bits drive a single combined interrupt to A. B's power-mode code is registered and passed to A. When it is not masked, a reset request from B also produces a one-cycle reset-request pulse toward A.

Top module: `core_b_rst_pwr_ctl`

## Requirements
- R1: After reset, `b_rst_o`, `b_boot_o`, `a_rst_req_o`, `sts_o`, `pmode_o` and `irq_o` are 0. With `b_stop_i` at 0, `b_clk_en_o` is 1.
- R2: `b_rst_o` is 1 in the same cycle whenever the force-reset field (control bit 0) is 1, the hold-reset field (control bit 2) is 1, or `b_unit_rst_i` is 1. Otherwise it is 0.
- R3: At each clock edge where `b_rst_o` is 1, `b_boot_o` loads the boot field (control bits 5:4; code 0 selects flash and code 2 selects local RAM). While `b_rst_o` is 0, `b_boot_o` does not change.
- R4: `b_clk_en_o` equals `!b_stop_i | (keep & !a_stop_i)`, where keep is the clock keep-alive field (control bit 3).
- R5: Each status bit is set one edge after its indication rises from 0 to 1. It stays set after the indication falls. An indication held at 1 does not set the bit again. Status bit positions are: 0 B left reset (`b_rst_exit_i`), 1 B entered reset (`b_rst_enter_i`), 2 B unit reset (`b_unit_rst_i`), 3 B reset request (`b_rst_req_i`).
- R6: Writing 1 to bit i of `sts_clr_i` clears status bit i at the next edge. If a set event and a clear for the same bit fall in the same cycle, the set wins.
- R7: With the request-mask field (control bit 1) at 0, a rising `b_rst_req_i` drives `a_rst_req_o` high for exactly one cycle and sets status bit 3. With the mask at 1, the rising edge affects neither.
- R8: `irq_o` is the OR over i of (status bit i AND enable bit i), where the enable word is loaded from `ien_wdata_i` when `ien_we_i` is 1 and uses the same bit positions as the status bits.
- R9: `pmode_o` shows the value of `b_pmode_i` one edge later, for every code (0 run, 1 compute-only, 2 wait, 3 stop, 4 deep sleep).
- R10: A control write (`ctl_we_i`) takes effect at the next edge, and the field layout is bit 0 force, bit 1 mask, bit 2 hold, bit 3 keep, bits 5:4 boot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Core-control write strobe |
| ctl_wdata_i | input | 6 | Core-control write data |
| ien_we_i | input | 1 | Interrupt-enable write strobe |
| ien_wdata_i | input | 4 | Interrupt-enable write data |
| sts_clr_i | input | 4 | Write-1-to-clear strobes for the status bits |
| b_rst_req_i | input | 1 | B requests a hardware reset of A |
| b_unit_rst_i | input | 1 | B unit reset is active |
| b_rst_enter_i | input | 1 | B has entered reset |
| b_rst_exit_i | input | 1 | B has left reset |
| b_pmode_i | input | PM_W | B power-mode code |
| a_stop_i | input | 1 | A is in a stop mode |
| b_stop_i | input | 1 | B is in a stop mode |
| b_rst_o | output | 1 | Reset line to B |
| b_boot_o | output | 2 | Boot-source code to B |
| b_clk_en_o | output | 1 | Clock enable for B |
| a_rst_req_o | output | 1 | One-cycle reset request toward A |
| sts_o | output | 4 | Sticky event status |
| pmode_o | output | PM_W | Registered B power mode |
| irq_o | output | 1 | Combined event interrupt toward A |

## Verification
The outputs `b_rst_o`, `b_clk_en_o` and `irq_o` are combinational from the registered control state and the live inputs, so the bench checks them a delta after it drives the inputs or right after the write edge. The status bits, `a_rst_req_o` and `pmode_o` are due exactly one edge after the input change, and `b_boot_o` is due one edge after the first edge at which reset is seen asserted. The bench therefore drives inputs 2 ns after a rising edge and samples 2 ns after the edge at which each result is due. The checks sweep all eight combinations of the reset sources, all eight clock-enable cases, all eight power-mode codes, and every enable word against each single status bit.

// File: rtl/core_b_pkg.sv
package core_b_pkg;
  localparam int BOOT_W = 2;
  localparam int CTL_W  = 4 + BOOT_W;
  localparam int N_EVT  = 4;

  // status / enable bit positions
  localparam int EV_EXIT  = 0;
  localparam int EV_ENTER = 1;
  localparam int EV_UNIT  = 2;
  localparam int EV_HWREQ = 3;

  typedef struct packed {
    logic [BOOT_W-1:0] boot_sel;
    logic              clk_keep;
    logic              hold_rst;
    logic              req_mask;
    logic              force_rst;
  } core_ctl_t;
endpackage

// File: rtl/core_b_ctl_regs.sv
module core_b_ctl_regs
  import core_b_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             ien_we_i,
  input  logic [N_EVT-1:0] ien_wdata_i,
  output core_ctl_t        ctl_o,
  output logic [N_EVT-1:0] ien_o
);
  core_ctl_t        ctl_q;
  logic [N_EVT-1:0] ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      ien_q <= '0;
    end else begin
      if (ctl_we_i) ctl_q <= core_ctl_t'(ctl_wdata_i);
      if (ien_we_i) ien_q <= ien_wdata_i;
    end
  end

  assign ctl_o = ctl_q;
  assign ien_o = ien_q;
endmodule

// File: rtl/core_b_evt_sticky.sv
module core_b_evt_sticky #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] qual_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] sts_o
);
  for (genvar i = 0; i < N; i++) begin : g_evt
    logic prev_q;
    logic sts_q;
    logic rise;

    assign rise = evt_i[i] & ~prev_q & qual_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        sts_q  <= 1'b0;
      end else begin
        prev_q <= evt_i[i];
        // set takes priority over clear
        sts_q  <= rise | (sts_q & ~clr_i[i]);
      end
    end

    assign rise_o[i] = rise;
    assign sts_o[i]  = sts_q;
  end
endmodule

// File: rtl/core_b_clk_pm.sv
module core_b_clk_pm #(
  parameter int PM_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            keep_i,
  input  logic            a_stop_i,
  input  logic            b_stop_i,
  input  logic [PM_W-1:0] pmode_i,
  output logic            clk_en_o,
  output logic [PM_W-1:0] pmode_o
);
  logic [PM_W-1:0] pmode_q;

  // keep-alive lasts until A stops too
  assign clk_en_o = ~b_stop_i | (keep_i & ~a_stop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pmode_q <= '0;
    else         pmode_q <= pmode_i;
  end

  assign pmode_o = pmode_q;
endmodule

// File: rtl/core_b_rst_pwr_ctl.sv
module core_b_rst_pwr_ctl
  import core_b_pkg::*;
#(
  parameter int PM_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ctl_we_i,
  input  logic [CTL_W-1:0]        ctl_wdata_i,
  input  logic                    ien_we_i,
  input  logic [N_EVT-1:0]        ien_wdata_i,
  input  logic [N_EVT-1:0]        sts_clr_i,
  input  logic                    b_rst_req_i,
  input  logic                    b_unit_rst_i,
  input  logic                    b_rst_enter_i,
  input  logic                    b_rst_exit_i,
  input  logic [PM_W-1:0]         b_pmode_i,
  input  logic                    a_stop_i,
  input  logic                    b_stop_i,
  output logic                    b_rst_o,
  output logic [BOOT_W-1:0]       b_boot_o,
  output logic                    b_clk_en_o,
  output logic                    a_rst_req_o,
  output logic [N_EVT-1:0]        sts_o,
  output logic [PM_W-1:0]         pmode_o,
  output logic                    irq_o
);
  core_ctl_t        ctl;
  logic [N_EVT-1:0] ien;
  logic [N_EVT-1:0] evt;
  logic [N_EVT-1:0] qual;
  logic [N_EVT-1:0] rise;
  logic [N_EVT-1:0] sts;
  logic             b_rst;
  logic [BOOT_W-1:0] boot_q;
  logic             a_req_q;
  logic             req_mask_w;
  logic             hold_w;

  core_b_ctl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_we_i    (ctl_we_i),
    .ctl_wdata_i (ctl_wdata_i),
    .ien_we_i    (ien_we_i),
    .ien_wdata_i (ien_wdata_i),
    .ctl_o       (ctl),
    .ien_o       (ien)
  );

  always_comb begin
    evt           = '0;
    evt[EV_EXIT]  = b_rst_exit_i;
    evt[EV_ENTER] = b_rst_enter_i;
    evt[EV_UNIT]  = b_unit_rst_i;
    evt[EV_HWREQ] = b_rst_req_i;
    qual           = '1;
    qual[EV_HWREQ] = ~ctl.req_mask;
  end

  core_b_evt_sticky #(.N(N_EVT)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .qual_i (qual),
    .clr_i  (sts_clr_i),
    .rise_o (rise),
    .sts_o  (sts)
  );

  core_b_clk_pm #(.PM_W(PM_W)) u_clk_pm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .keep_i   (ctl.clk_keep),
    .a_stop_i (a_stop_i),
    .b_stop_i (b_stop_i),
    .pmode_i  (b_pmode_i),
    .clk_en_o (b_clk_en_o),
    .pmode_o  (pmode_o)
  );

  assign b_rst = ctl.force_rst | ctl.hold_rst | b_unit_rst_i;

  // boot code tracks the field while in reset, frozen once released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q  <= '0;
      a_req_q <= 1'b0;
    end else begin
      if (b_rst) boot_q <= ctl.boot_sel;
      a_req_q <= rise[EV_HWREQ];
    end
  end

  assign req_mask_w  = ctl.req_mask;
  assign hold_w      = ctl.hold_rst;
  assign b_rst_o     = b_rst;
  assign b_boot_o    = boot_q;
  assign a_rst_req_o = a_req_q;
  assign sts_o       = sts;
  assign irq_o       = |(sts & ien);
endmodule

// File: rtl/core_b_rst_pwr_chk.sv
module core_b_rst_pwr_chk
  import core_b_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_mask,
  input logic              hold,
  input logic              b_stop_i,
  input logic              b_rst_o,
  input logic [BOOT_W-1:0] b_boot_o,
  input logic              b_clk_en_o,
  input logic              a_rst_req_o,
  input logic [N_EVT-1:0]  sts_o,
  input logic [N_EVT-1:0]  sts_clr_i,
  input logic              irq_o
);
  a_r2_hold_gives_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |-> b_rst_o);

  a_r3_boot_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!b_rst_o) |-> $stable(b_boot_o));

  a_r4_run_clk_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_stop_i |-> b_clk_en_o);

  a_r5_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_o & $past(sts_o & ~sts_clr_i)) == $past(sts_o & ~sts_clr_i)));

  a_r7_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rst_req_o |=> !a_rst_req_o);

  a_r7_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rst_req_o |-> $past(!req_mask));

  a_r8_irq_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sts_o != '0));
endmodule

bind core_b_rst_pwr_ctl core_b_rst_pwr_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_mask    (req_mask_w),
  .hold        (hold_w),
  .b_stop_i    (b_stop_i),
  .b_rst_o     (b_rst_o),
  .b_boot_o    (b_boot_o),
  .b_clk_en_o  (b_clk_en_o),
  .a_rst_req_o (a_rst_req_o),
  .sts_o       (sts_o),
  .sts_clr_i   (sts_clr_i),
  .irq_o       (irq_o)
);

// File: tb/core_b_rst_pwr_ctl_bench.sv
`timescale 1ns/1ps
module core_b_rst_pwr_ctl_bench;
  localparam int PM_W = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_we_i = 1'b0;
  logic [5:0] ctl_wdata_i = '0;
  logic       ien_we_i = 1'b0;
  logic [3:0] ien_wdata_i = '0;
  logic [3:0] sts_clr_i = '0;
  logic       b_rst_req_i = 1'b0;
  logic       b_unit_rst_i = 1'b0;
  logic       b_rst_enter_i = 1'b0;
  logic       b_rst_exit_i = 1'b0;
  logic [PM_W-1:0] b_pmode_i = '0;
  logic       a_stop_i = 1'b0;
  logic       b_stop_i = 1'b0;
  logic       b_rst_o;
  logic [1:0] b_boot_o;
  logic       b_clk_en_o;
  logic       a_rst_req_o;
  logic [3:0] sts_o;
  logic [PM_W-1:0] pmode_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  core_b_rst_pwr_ctl #(.PM_W(PM_W)) u_core_b_rst_pwr_ctl (
    .clk_i(clk), .rst_ni(rst_ni),
    .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
    .ien_we_i(ien_we_i), .ien_wdata_i(ien_wdata_i),
    .sts_clr_i(sts_clr_i),
    .b_rst_req_i(b_rst_req_i), .b_unit_rst_i(b_unit_rst_i),
    .b_rst_enter_i(b_rst_enter_i), .b_rst_exit_i(b_rst_exit_i),
    .b_pmode_i(b_pmode_i), .a_stop_i(a_stop_i), .b_stop_i(b_stop_i),
    .b_rst_o(b_rst_o), .b_boot_o(b_boot_o), .b_clk_en_o(b_clk_en_o),
    .a_rst_req_o(a_rst_req_o), .sts_o(sts_o), .pmode_o(pmode_o),
    .irq_o(irq_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_ctl(logic [5:0] d);
    ctl_we_i = 1'b1; ctl_wdata_i = d;
    tick();
    ctl_we_i = 1'b0;
  endtask

  task automatic wr_ien(logic [3:0] d);
    ien_we_i = 1'b1; ien_wdata_i = d;
    tick();
    ien_we_i = 1'b0;
  endtask

  task automatic clr_all();
    sts_clr_i = 4'hF;
    tick();
    sts_clr_i = 4'h0;
  endtask

  task automatic set_evt(int i, logic v);
    case (i)
      0: b_rst_exit_i  = v;
      1: b_rst_enter_i = v;
      2: b_unit_rst_i  = v;
      default: b_rst_req_i = v;
    endcase
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    check("R1 b_rst_o", b_rst_o, 0);
    check("R1 b_boot_o", b_boot_o, 0);
    check("R1 b_clk_en_o", b_clk_en_o, 1);
    check("R1 a_rst_req_o", a_rst_req_o, 0);
    check("R1 sts_o", sts_o, 0);
    check("R1 pmode_o", pmode_o, 0);
    check("R1 irq_o", irq_o, 0);

    // R2 / R10 reset sources
    for (int k = 0; k < 8; k++) begin
      wr_ctl({3'b000, k[1], 1'b0, k[0]});
      b_unit_rst_i = k[2];
      #1;
      check("R2 b_rst_o", b_rst_o, k[0] | k[1] | k[2]);
    end
    b_unit_rst_i = 1'b0;
    wr_ctl(6'b0);
    #1 check("R10 released", b_rst_o, 0);

    // R3 boot capture
    wr_ctl(6'b10_0_1_0_0);
    tick();
    check("R3 boot in hold", b_boot_o, 2);
    wr_ctl(6'b01_0_1_0_0);
    tick();
    check("R3 boot follows", b_boot_o, 1);
    wr_ctl(6'b01_0_0_0_0);
    tick();
    check("R3 boot at release", b_boot_o, 1);
    wr_ctl(6'b10_0_0_0_0);
    tick(); tick();
    check("R3 boot frozen", b_boot_o, 1);
    b_unit_rst_i = 1'b1;
    tick();
    check("R3 boot via unit reset", b_boot_o, 2);
    b_unit_rst_i = 1'b0;
    wr_ctl(6'b0);

    // R4 clock enable sweep
    for (int k = 0; k < 8; k++) begin
      wr_ctl({2'b00, k[2], 3'b000});
      a_stop_i = k[1];
      b_stop_i = k[0];
      #1;
      check("R4 b_clk_en_o", b_clk_en_o, !k[0] | (k[2] & !k[1]));
    end
    a_stop_i = 1'b0; b_stop_i = 1'b0;
    wr_ctl(6'b0);

    // R9 power mode
    for (int c = 0; c < 8; c++) begin
      b_pmode_i = c[PM_W-1:0];
      tick();
      check("R9 pmode_o", pmode_o, c);
    end

    // R5 sticky set
    clr_all();
    check("R6 cleared", sts_o, 0);
    b_rst_enter_i = 1'b1;
    tick();
    check("R5 enter set", sts_o, 4'b0010);
    b_rst_enter_i = 1'b0;
    tick(); tick();
    check("R5 enter sticky", sts_o, 4'b0010);
    b_rst_exit_i = 1'b1;
    tick();
    check("R5 exit set", sts_o, 4'b0011);
    b_rst_exit_i = 1'b0;
    // R6 clear
    sts_clr_i = 4'b0010;
    tick();
    sts_clr_i = 4'b0;
    check("R6 w1c", sts_o, 4'b0001);
    b_rst_exit_i = 1'b1;
    sts_clr_i = 4'b0001;
    tick();
    check("R6 set wins", sts_o, 4'b0001);
    tick();
    sts_clr_i = 4'b0;
    check("R6 clear held input", sts_o, 4'b0000);
    tick();
    check("R5 no reset on level", sts_o, 4'b0000);
    b_rst_exit_i = 1'b0;

    // R7 hardware reset request
    clr_all();
    b_rst_req_i = 1'b1;
    tick();
    check("R7 req pulse", a_rst_req_o, 1);
    check("R7 sts bit3", sts_o, 4'b1000);
    tick();
    check("R7 pulse ends", a_rst_req_o, 0);
    b_rst_req_i = 1'b0;
    clr_all();
    wr_ctl(6'b000010);
    b_rst_req_i = 1'b1;
    tick();
    check("R7 masked pulse", a_rst_req_o, 0);
    check("R7 masked sts", sts_o, 0);
    tick();
    check("R7 masked later", a_rst_req_o, 0);
    b_rst_req_i = 1'b0;
    wr_ctl(6'b0);

    // R8 interrupt combine
    clr_all();
    for (int i = 0; i < 4; i++) set_evt(i, 1'b1);
    tick();
    for (int i = 0; i < 4; i++) set_evt(i, 1'b0);
    check("R8 all set", sts_o, 4'hF);
    for (int e = 0; e < 16; e++) begin
      wr_ien(e[3:0]);
      check("R8 irq all", irq_o, e != 0);
    end
    for (int i = 0; i < 4; i++) begin
      clr_all();
      set_evt(i, 1'b1);
      tick();
      set_evt(i, 1'b0);
      check("R5 single event", sts_o, 1 << i);
      for (int e = 0; e < 16; e++) begin
        wr_ien(e[3:0]);
        check("R8 irq single", irq_o, e[i]);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule